// File: doc/BRIEF.md
# Daisy-Chained Register Access Node

This block is one link in a pass-through register chain. Every cycle it captures the request, acknowledge, read/write-not, address, data and source signals on its inputs. One clock later it presents them on its outputs, so the nodes after it see the same traffic. A request is meaningful only in the cycle its request bit is high.

The node owns a request when three things hold: request is high, acknowledge is still low, and address bits 22:6 equal the parameter `BLOCK_TAG` (default 0x1). When it owns a request it raises acknowledge on the forwarded copy and serves the request from a local bank of 32-bit registers selected by address bits 5:0. A read substitutes the register value into the forwarded data field. A write stores the incoming data and forwards that data unchanged. Requests that another node has already acknowledged are passed on untouched.

Top module: `chain_reg_node`

## Requirements
- R1: A synchronous active-high reset drives every output to 0 and clears every implemented register to 0.
- R2: out_req, out_rd_nwr, out_addr and out_src equal the values in_req, in_rd_nwr, in_addr and in_src had one cycle earlier. There is no other latency and no modification.
- R3: A request with in_req=1, in_ack=0 and in_addr[22:6]==BLOCK_TAG is owned. One cycle later out_ack is 1.
- R4: A request whose in_addr[22:6] differs from BLOCK_TAG is forwarded with its ack and data values unchanged.
- R5: A request that arrives with in_ack=1 is not served: ack and data are forwarded unchanged, and no register is written.
- R6: An owned write (in_rd_nwr=0) with index in_addr[5:0] below NUM_REGS (default 8) stores in_data into that register. The forwarded data stays equal to in_data.
- R7: An owned read (in_rd_nwr=1) of an implemented index forwards that register's current contents as out_data. This includes a value written by the request immediately before.
- R8: An owned read of an index at or above NUM_REGS forwards 0xDEADBEEF as out_data, with out_ack=1.
- R9: An owned write to an index at or above NUM_REGS changes no register. In particular, it does not alias onto a lower index.
- R10: When in_req=0, no register is written, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Request valid from previous node |
| in_ack | input | 1 | Request already claimed upstream |
| in_rd_nwr | input | 1 | 1 = read, 0 = write |
| in_addr | input | 23 | Chain address |
| in_data | input | 32 | Write data or read data so far |
| in_src | input | 2 | Request source, passed through |
| out_req | output | 1 | Forwarded request |
| out_ack | output | 1 | Forwarded acknowledge, set when owned |
| out_rd_nwr | output | 1 | Forwarded read/write-not |
| out_addr | output | 23 | Forwarded address |
| out_data | output | 32 | Forwarded data, read data on owned reads |
| out_src | output | 2 | Forwarded source |

## Verification
The bench sends back-to-back writes followed by reads to every implemented index. This separates correct per-register storage and read substitution from stuck or aliased registers, and it covers a read that immediately follows a write. Three kinds of request are aimed at a register and then read back: requests with a foreign tag, requests carrying an upstream acknowledge, and idle cycles with matching addresses. A changed value in the readback would show that one of the ignore conditions is broken. Reads and writes beyond the implemented range tell the 0xDEADBEEF fill apart from register contents, and show whether upper index bits are dropped into an alias.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;
    localparam int ADDR_W = 23;
    localparam int DATA_W = 32;
    localparam int SRC_W  = 2;
    localparam int IDX_W  = 6;
    localparam int TAG_W  = ADDR_W - IDX_W;

    localparam logic [DATA_W-1:0] UNMAPPED_FILL = 32'hDEADBEEF;

    typedef struct packed {
        logic              req;
        logic              ack;
        logic              rd_nwr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SRC_W-1:0]  src;
    } chain_beat_t;

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/chain_addr_decode.sv
module chain_addr_decode
    import chain_node_pkg::*;
#(
    parameter logic [TAG_W-1:0] BLOCK_TAG = 17'h1,
    parameter int               NUM_REGS  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              tag_hit,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              idx_impl
);
    localparam logic [IDX_W:0] NUM_L = NUM_REGS[IDX_W:0];

    always_comb begin
        tag_hit  = (tag_of(addr) == BLOCK_TAG);
        reg_idx  = idx_of(addr);
        idx_impl = ({1'b0, reg_idx} < NUM_L);
    end
endmodule

// File: rtl/chain_reg_bank.sv
module chain_reg_bank
    import chain_node_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
    end

    logic [SEL_W-1:0] rd_sel;
    always_comb begin
        rd_sel  = rd_idx[SEL_W-1:0];
        rd_data = '0;
        if (int'(rd_sel) < NUM_REGS)
            rd_data = regs[rd_sel];
    end
endmodule

// File: rtl/chain_reg_node.sv
module chain_reg_node
    import chain_node_pkg::*;
#(
    parameter logic [TAG_W-1:0] BLOCK_TAG = 17'h1,
    parameter int               NUM_REGS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_req,
    input  logic              in_ack,
    input  logic              in_rd_nwr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SRC_W-1:0]  in_src,
    output logic              out_req,
    output logic              out_ack,
    output logic              out_rd_nwr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [SRC_W-1:0]  out_src
);
    chain_beat_t in_beat, nxt_beat, out_beat;
    logic              tag_hit, idx_impl, owned, wr_en;
    logic [IDX_W-1:0]  reg_idx;
    logic [DATA_W-1:0] bank_rd;

    assign in_beat = '{req: in_req, ack: in_ack, rd_nwr: in_rd_nwr,
                       addr: in_addr, data: in_data, src: in_src};

    chain_addr_decode #(.BLOCK_TAG(BLOCK_TAG), .NUM_REGS(NUM_REGS)) u_dec (
        .addr     (in_addr),
        .tag_hit  (tag_hit),
        .reg_idx  (reg_idx),
        .idx_impl (idx_impl)
    );

    assign owned = in_req && !in_ack && tag_hit;
    assign wr_en = owned && !in_rd_nwr && idx_impl;

    chain_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (reg_idx),
        .wr_data (in_data),
        .rd_idx  (reg_idx),
        .rd_data (bank_rd)
    );

    always_comb begin
        nxt_beat = in_beat;
        if (owned) begin
            nxt_beat.ack = 1'b1;
            if (in_rd_nwr)
                nxt_beat.data = idx_impl ? bank_rd : UNMAPPED_FILL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_beat <= '0;
        else     out_beat <= nxt_beat;
    end

    assign out_req    = out_beat.req;
    assign out_ack    = out_beat.ack;
    assign out_rd_nwr = out_beat.rd_nwr;
    assign out_addr   = out_beat.addr;
    assign out_data   = out_beat.data;
    assign out_src    = out_beat.src;

    p_forward_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_req == $past(in_req) && out_rd_nwr == $past(in_rd_nwr)
                  && out_addr == $past(in_addr) && out_src == $past(in_src)));

    p_claim_r3: assert property (@(posedge clk) disable iff (rst)
        (in_req && !in_ack && tag_hit) |=> out_ack);

    p_foreign_r4: assert property (@(posedge clk) disable iff (rst)
        (in_req && !tag_hit) |=> (out_ack == $past(in_ack) && out_data == $past(in_data)));

    p_upstream_r5: assert property (@(posedge clk) disable iff (rst)
        (in_req && in_ack) |=> (out_ack && out_data == $past(in_data)));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
        (in_req && !in_ack && tag_hit && in_rd_nwr && !idx_impl) |=> (out_data == UNMAPPED_FILL));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!in_req && $past(!in_req)) |=> !out_ack || $past(in_ack));
endmodule

// File: tb/test_chain_reg_node.sv
module test_chain_reg_node;
    import chain_node_pkg::*;

    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_req = 1'b0, in_ack = 1'b0, in_rd_nwr = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [SRC_W-1:0]  in_src  = '0;
    logic out_req, out_ack, out_rd_nwr;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic [SRC_W-1:0]  out_src;

    always #5 clk = ~clk;

    chain_reg_node i_chain_reg_node (
        .clk(clk), .rst(rst),
        .in_req(in_req), .in_ack(in_ack), .in_rd_nwr(in_rd_nwr),
        .in_addr(in_addr), .in_data(in_data), .in_src(in_src),
        .out_req(out_req), .out_ack(out_ack), .out_rd_nwr(out_rd_nwr),
        .out_addr(out_addr), .out_data(out_data), .out_src(out_src)
    );

    int compared = 0;
    int mismatched = 0;
    logic [DATA_W-1:0] model [64];
    chain_beat_t exp_q [$];
    string       tag_q [$];
    bit          done = 1'b0;

    function automatic logic [ADDR_W-1:0] own_addr(input int idx);
        return {17'h1, 6'(idx)};
    endfunction

    task automatic send(input logic ack, input logic rd, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [SRC_W-1:0] s,
                        input string rq);
        chain_beat_t e;
        bit own;
        int idx;
        @(negedge clk);
        in_req = 1'b1; in_ack = ack; in_rd_nwr = rd;
        in_addr = a; in_data = d; in_src = s;
        own = !ack && (a[22:6] == 17'h1);
        idx = int'(a[5:0]);
        e = '{req: 1'b1, ack: ack | own, rd_nwr: rd, addr: a, data: d, src: s};
        if (own && rd) e.data = (idx < NREG) ? model[idx] : 32'hDEADBEEF;
        if (own && !rd && idx < NREG) model[idx] = d;
        exp_q.push_back(e);
        tag_q.push_back(rq);
    endtask

    task automatic idle(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_req = 1'b0; in_ack = 1'b0; in_rd_nwr = 1'b0; in_addr = a; in_data = d;
    endtask

    // monitor: outputs change at posedge, sample 2 ns later
    always @(posedge clk) begin
        #2;
        if (!rst && out_req) begin
            chain_beat_t e, got;
            string rq;
            got = '{req: out_req, ack: out_ack, rd_nwr: out_rd_nwr,
                    addr: out_addr, data: out_data, src: out_src};
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected beat R2 actual %h expected none", got);
            end else begin
                e = exp_q.pop_front();
                rq = tag_q.pop_front();
                if (got !== e) begin
                    mismatched++;
                    $display("FAIL %s actual %h expected %h", rq, got, e);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        compared++;
        if ({out_req, out_ack, out_rd_nwr, out_addr, out_data, out_src} !== '0) begin
            mismatched++;
            $display("FAIL R1 reset outputs actual %h expected 0",
                     {out_req, out_ack, out_rd_nwr, out_addr, out_data, out_src});
        end
        // R1: registers read zero after reset
        for (int i = 0; i < NREG; i++) send(1'b0, 1'b1, own_addr(i), 32'h5555_0000, 2'd1, "R1 reset read");
        // R6 / R3: back-to-back writes
        for (int i = 0; i < NREG; i++) send(1'b0, 1'b0, own_addr(i), 32'hA000_0000 + 32'(i * 17), 2'(i), "R6 owned write");
        // R7: readback, including read right after write
        for (int i = 0; i < NREG; i++) send(1'b0, 1'b1, own_addr(i), 32'h0, 2'(3 - i % 4), "R7 owned read");
        send(1'b0, 1'b0, own_addr(3), 32'hCAFE_F00D, 2'd2, "R6 write");
        send(1'b0, 1'b1, own_addr(3), 32'h1111_1111, 2'd0, "R7 read after write");
        // R8: unimplemented reads
        send(1'b0, 1'b1, own_addr(9), 32'h0, 2'd1, "R8 unmapped read");
        send(1'b0, 1'b1, own_addr(63), 32'h1234_5678, 2'd3, "R8 unmapped read");
        // R9: write to index 8 must not alias to 0
        send(1'b0, 1'b0, own_addr(8), 32'hBAD0_0008, 2'd0, "R9 unmapped write");
        send(1'b0, 1'b1, own_addr(0), 32'h0, 2'd0, "R9 no alias readback");
        // R4: foreign tags
        send(1'b0, 1'b0, {17'h2, 6'd1}, 32'hF0F0_F0F0, 2'd1, "R4 foreign write");
        send(1'b0, 1'b1, {17'h0, 6'd1}, 32'h0F0F_0F0F, 2'd2, "R4 foreign read");
        send(1'b0, 1'b0, {17'h10001, 6'd1}, 32'h7777_7777, 2'd3, "R4 foreign write");
        send(1'b0, 1'b1, own_addr(1), 32'h0, 2'd0, "R4 readback");
        // R5: upstream-acked requests
        send(1'b1, 1'b0, own_addr(1), 32'hDEAD_0001, 2'd2, "R5 acked write");
        send(1'b1, 1'b1, own_addr(2), 32'h2222_2222, 2'd1, "R5 acked read");
        send(1'b0, 1'b1, own_addr(1), 32'h0, 2'd0, "R5 readback");
        // R10: idle cycles with matching address
        idle(own_addr(2), 32'h9999_9999);
        idle(own_addr(2), 32'h8888_8888);
        send(1'b0, 1'b1, own_addr(2), 32'h0, 2'd3, "R10 readback after idle");
        // R2: spaced requests
        idle('0, '0);
        send(1'b0, 1'b1, {17'h3, 6'd5}, 32'h4444_4444, 2'd3, "R2 forward");
        idle('0, '0);
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R2 missing beats actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule